// File: doc/BRIEF.md
# Day-Counting Real-Time Clock with Alarm

This block keeps wall-clock time for a chip as four separate counters: seconds, minutes, hours and a day count. It is driven by a single-cycle tick input, one pulse per period of a slow reference oscillator that has already been brought into the core clock domain. A prescaler divides these ticks down to an exact one-second step. Software picks which of three reference rates is fitted through a control register, and a second bit in that register starts or stops counting.

Software uses a 16-bit register bus to read and set the time and to program an alarm of the same format. Three events are recorded in a status register: a half-second beat, a one-second beat and the alarm match. Each status bit is cleared by writing a 1 to it. An enable register masks these bits onto one level-sensitive interrupt line. The bus decodes byte offsets with a spacing of four bytes, so driver code can address it as 32-bit slots.

Top module: `daytime_rtc`

## Requirements
- R1: After reset, every register reads 0, the prescaler count is 0 and `irq` is low.
- R2: The control register at offset 0x10 stores a run bit in bit 7 and a reference select in bits 6:5, and all other bits read 0. When bit 7 is 0, reference ticks do not advance the prescaler or the time, and they set no status bit.
- R3: The seconds value advances by one after exactly DIV_A, DIV_B or DIV_C reference ticks for select 00, 01 or 10. These parameters default to 32768, 32000 and 38400. Select 11 behaves like 00.
- R4: Status bit 4 (one-second) sets on the tick that ends a second. Status bit 7 (half-second) sets on that tick and also on the tick that ends the first half of the count.
- R5: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day count. The day count wraps from its maximum to 0.
- R6: The hour/minute register (0x00) and the alarm hour/minute register (0x08) hold hours in bits 12:8 and minutes in bits 5:0. The seconds register (0x04) and the alarm seconds register (0x0C) hold the value in bits 5:0. The day register (0x20) and the day alarm register (0x24) hold DAY_W bits (default 16). Bits without storage read 0.
- R7: A write to the day, hour/minute or seconds register takes effect at the next clock edge. If it falls in the same cycle as a one-second step, the written value is loaded and the time does not advance in that cycle.
- R8: Status bit 2 (alarm) sets when a one-second step brings day, hour, minute and second all equal to the alarm registers. The bit does not set while the time only stays equal, and it does not set when the day differs.
- R9: The status register (0x14) is write-one-to-clear: a 1 clears the bit and a 0 leaves it. An event that arrives in the same cycle as the clear keeps the bit set. Bits 0, 1, 3, 5, 6 and 15:8 always read 0.
- R10: The enable register (0x18) stores bits 2, 4 and 7 only. `irq` is high exactly when some status bit and the matching enable bit are both 1. Status bits set even when their enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference oscillator period |
| bus_addr | input | BUS_AW (6) | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach from the ports is a full carry chain. It starts at 23:59:59 on the last day and ends with every field at zero on a single step. An alarm match on a step boundary is similar, and so are a bus write or status clear that falls exactly on the edge of a one-second step. The bench overrides the divisors with small even values and presets the time through the bus just before a boundary. It then counts reference ticks exactly, so the cycle holding the one-second step is known in advance. Writes are placed into that cycle, and the results are checked for the write taking priority over the step and for the event taking priority over the clear.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Byte offsets decoded on the register bus
  localparam int unsigned OFS_HM      = 8'h00;
  localparam int unsigned OFS_SEC     = 8'h04;
  localparam int unsigned OFS_ALM_HM  = 8'h08;
  localparam int unsigned OFS_ALM_SEC = 8'h0C;
  localparam int unsigned OFS_CTRL    = 8'h10;
  localparam int unsigned OFS_STATUS  = 8'h14;
  localparam int unsigned OFS_ENABLE  = 8'h18;
  localparam int unsigned OFS_DAY     = 8'h20;
  localparam int unsigned OFS_ALM_DAY = 8'h24;

  // Status / enable bit positions
  localparam int unsigned ST_ALARM = 2;
  localparam int unsigned ST_SEC   = 4;
  localparam int unsigned ST_HALF  = 7;
  localparam logic [15:0] ST_IMPL  = 16'((1 << ST_ALARM) | (1 << ST_SEC) | (1 << ST_HALF));

  // Control bit positions
  localparam int unsigned CTL_RUN    = 7;
  localparam int unsigned CTL_SEL_LO = 5;

  typedef enum logic [1:0] {
    REF_A    = 2'b00,
    REF_B    = 2'b01,
    REF_C    = 2'b10,
    REF_RSVD = 2'b11
  } ref_sel_e;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } hms_t;

  function automatic int unsigned pick_div(ref_sel_e sel, int unsigned a,
                                           int unsigned b, int unsigned c);
    case (sel)
      REF_B:   return b;
      REF_C:   return c;
      default: return a;
    endcase
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // One-second advance of the time-of-day fields
  function automatic hms_t hms_step(hms_t t);
    hms_t n;
    n = t;
    if (t.sc >= 6'd59) begin
      n.sc = '0;
      if (t.mn >= 6'd59) begin
        n.mn = '0;
        n.hr = (t.hr >= 5'd23) ? 5'd0 : t.hr + 5'd1;
      end else begin
        n.mn = t.mn + 6'd1;
      end
    end else begin
      n.sc = t.sc + 6'd1;
    end
    return n;
  endfunction

  // True when the next step crosses midnight
  function automatic logic day_roll(hms_t t);
    return (t.sc >= 6'd59) && (t.mn >= 6'd59) && (t.hr >= 5'd23);
  endfunction

  function automatic logic [15:0] pack_hm(hms_t t);
    return {3'b000, t.hr, 2'b00, t.mn};
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_A = 32768,
  parameter int unsigned DIV_B = 32000,
  parameter int unsigned DIV_C = 38400
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  ref_sel_e sel,
  input  logic     ref_tick,
  output logic     sec_pulse,
  output logic     half_pulse
);

  localparam int unsigned DIV_MAX = max3(DIV_A, DIV_B, DIV_C);
  localparam int unsigned CNT_W   = $clog2(DIV_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic [CNT_W-1:0] mid_val;
  int unsigned      divisor;
  logic             tick_en;
  logic             at_end;

  always_comb begin
    divisor  = pick_div(sel, DIV_A, DIV_B, DIV_C);
    last_val = CNT_W'(divisor - 1);
    mid_val  = CNT_W'((divisor / 2) - 1);
  end

  assign tick_en    = run && ref_tick;
  assign at_end     = (cnt_q >= last_val);
  assign sec_pulse  = tick_en && at_end;
  assign half_pulse = tick_en && (at_end || (cnt_q == mid_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int unsigned DAY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             wr_hm,
  input  logic             wr_sec,
  input  logic             wr_day,
  input  logic [15:0]      wdata,
  input  hms_t             alm_hms,
  input  logic [DAY_W-1:0] alm_day,
  output hms_t             now_hms,
  output logic [DAY_W-1:0] now_day,
  output logic             alarm_evt
);

  logic             any_wr;
  logic             advance;
  hms_t             nxt_hms;
  logic [DAY_W-1:0] nxt_day;

  assign any_wr  = wr_hm || wr_sec || wr_day;
  assign advance = step && !any_wr;
  assign nxt_hms = hms_step(now_hms);
  assign nxt_day = day_roll(now_hms) ? now_day + 1'b1 : now_day;

  assign alarm_evt = advance && (nxt_hms == alm_hms) && (nxt_day == alm_day);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_hms <= '0;
      now_day <= '0;
    end else if (advance) begin
      now_hms <= nxt_hms;
      now_day <= nxt_day;
    end else begin
      if (wr_hm) begin
        now_hms.hr <= wdata[12:8];
        now_hms.mn <= wdata[5:0];
      end
      if (wr_sec) now_hms.sc <= wdata[5:0];
      if (wr_day) now_day <= wdata[DAY_W-1:0];
    end
  end

endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_alarm,
  input  logic        evt_sec,
  input  logic        evt_half,
  input  logic        st_wr,
  input  logic        en_wr,
  input  logic [15:0] wdata,
  output logic [15:0] status_q,
  output logic [15:0] enable_q,
  output logic        irq
);

  logic [15:0] evt_vec;

  always_comb begin
    evt_vec           = '0;
    evt_vec[ST_ALARM] = evt_alarm;
    evt_vec[ST_SEC]   = evt_sec;
    evt_vec[ST_HALF]  = evt_half;
  end

  for (genvar i = 0; i < 16; i++) begin : g_bit
    if (ST_IMPL[i]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          status_q[i] <= 1'b0;
          enable_q[i] <= 1'b0;
        end else begin
          if (evt_vec[i])              status_q[i] <= 1'b1;
          else if (st_wr && wdata[i])  status_q[i] <= 1'b0;
          if (en_wr)                   enable_q[i] <= wdata[i];
        end
      end
    end else begin : g_none
      assign status_q[i] = 1'b0;
      assign enable_q[i] = 1'b0;
    end
  end

  assign irq = |(status_q & enable_q);

endmodule

// File: rtl/daytime_rtc.sv
module daytime_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_A  = 32768,
  parameter int unsigned DIV_B  = 32000,
  parameter int unsigned DIV_C  = 38400,
  parameter int unsigned DAY_W  = 16,
  parameter int unsigned BUS_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq
);

  // Address hits
  logic hit_hm, hit_sec, hit_ahm, hit_asec, hit_ctrl, hit_st, hit_en, hit_day, hit_aday;
  assign hit_hm   = (bus_addr == BUS_AW'(OFS_HM));
  assign hit_sec  = (bus_addr == BUS_AW'(OFS_SEC));
  assign hit_ahm  = (bus_addr == BUS_AW'(OFS_ALM_HM));
  assign hit_asec = (bus_addr == BUS_AW'(OFS_ALM_SEC));
  assign hit_ctrl = (bus_addr == BUS_AW'(OFS_CTRL));
  assign hit_st   = (bus_addr == BUS_AW'(OFS_STATUS));
  assign hit_en   = (bus_addr == BUS_AW'(OFS_ENABLE));
  assign hit_day  = (bus_addr == BUS_AW'(OFS_DAY));
  assign hit_aday = (bus_addr == BUS_AW'(OFS_ALM_DAY));

  logic wr_hm, wr_sec, wr_day, time_wr, st_wr, en_wr;
  assign wr_hm   = bus_we && hit_hm;
  assign wr_sec  = bus_we && hit_sec;
  assign wr_day  = bus_we && hit_day;
  assign time_wr = wr_hm || wr_sec || wr_day;
  assign st_wr   = bus_we && hit_st;
  assign en_wr   = bus_we && hit_en;

  // Control and alarm registers
  logic             run;
  ref_sel_e         ref_sel;
  hms_t             alm_hms;
  logic [DAY_W-1:0] alm_day;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      ref_sel <= REF_A;
      alm_hms <= '0;
      alm_day <= '0;
    end else if (bus_we) begin
      if (hit_ctrl) begin
        run     <= bus_wdata[CTL_RUN];
        ref_sel <= ref_sel_e'(bus_wdata[CTL_SEL_LO +: 2]);
      end
      if (hit_ahm) begin
        alm_hms.hr <= bus_wdata[12:8];
        alm_hms.mn <= bus_wdata[5:0];
      end
      if (hit_asec) alm_hms.sc <= bus_wdata[5:0];
      if (hit_aday) alm_day    <= bus_wdata[DAY_W-1:0];
    end
  end

  // Internal events brought out as named wires
  logic             sec_pulse;
  logic             half_pulse;
  logic             alarm_evt;
  hms_t             now_hms;
  logic [DAY_W-1:0] now_day;
  logic [15:0]      status_q;
  logic [15:0]      enable_q;

  rtc_prescaler #(
    .DIV_A(DIV_A),
    .DIV_B(DIV_B),
    .DIV_C(DIV_C)
  ) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sel       (ref_sel),
    .ref_tick  (ref_tick),
    .sec_pulse (sec_pulse),
    .half_pulse(half_pulse)
  );

  rtc_timekeeper #(
    .DAY_W(DAY_W)
  ) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (sec_pulse),
    .wr_hm    (wr_hm),
    .wr_sec   (wr_sec),
    .wr_day   (wr_day),
    .wdata    (bus_wdata),
    .alm_hms  (alm_hms),
    .alm_day  (alm_day),
    .now_hms  (now_hms),
    .now_day  (now_day),
    .alarm_evt(alarm_evt)
  );

  rtc_irq_regs u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_alarm(alarm_evt),
    .evt_sec  (sec_pulse),
    .evt_half (half_pulse),
    .st_wr    (st_wr),
    .en_wr    (en_wr),
    .wdata    (bus_wdata),
    .status_q (status_q),
    .enable_q (enable_q),
    .irq      (irq)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (1'b1)
      hit_hm:   bus_rdata = pack_hm(now_hms);
      hit_sec:  bus_rdata = {10'b0, now_hms.sc};
      hit_ahm:  bus_rdata = pack_hm(alm_hms);
      hit_asec: bus_rdata = {10'b0, alm_hms.sc};
      hit_ctrl: bus_rdata = 16'({run, ref_sel}) << CTL_SEL_LO;
      hit_st:   bus_rdata = status_q;
      hit_en:   bus_rdata = enable_q;
      hit_day:  bus_rdata = 16'(now_day);
      hit_aday: bus_rdata = 16'(alm_day);
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int unsigned DAY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             sec_pulse,
  input logic             half_pulse,
  input logic             time_wr,
  input logic             wr_sec,
  input logic             alarm_evt,
  input hms_t             now_hms,
  input logic [DAY_W-1:0] now_day,
  input hms_t             alm_hms,
  input logic [DAY_W-1:0] alm_day,
  input logic             st_wr,
  input logic [15:0]      wdata,
  input logic [15:0]      status_q,
  input logic [15:0]      enable_q,
  input logic             irq
);

  // R2: a stopped clock produces no beats
  a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!sec_pulse && !half_pulse));

  // R3: seconds only move on a one-second step or a bus write
  a_r3_sec_moves_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(now_hms.sc) |-> $past(sec_pulse || time_wr));

  // R4: the end of a second is also a half-second beat
  a_r4_half_on_second: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> half_pulse);

  // R7: a time write in a step cycle blocks the advance of seconds
  a_r7_write_blocks_step: assert property (@(posedge clk) disable iff (!rst_n)
    (time_wr && sec_pulse && !wr_sec) |=> $stable(now_hms.sc));

  // R8: an alarm event lands the time exactly on the alarm value
  a_r8_alarm_lands: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> ((now_hms == alm_hms) && (now_day == alm_day)));

  // R9: writing 1 to the alarm status bit clears it when no event competes
  a_r9_w1c_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wdata[ST_ALARM] && !alarm_evt) |=> !status_q[ST_ALARM]);

  // R10: no interrupt without an enabled pending bit
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q) == 16'h0000) |-> !irq);

  // R9: unimplemented status bits never set
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~ST_IMPL) == 16'h0000);

endmodule

bind daytime_rtc rtc_checker #(.DAY_W(DAY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .sec_pulse (sec_pulse),
  .half_pulse(half_pulse),
  .time_wr   (time_wr),
  .wr_sec    (wr_sec),
  .alarm_evt (alarm_evt),
  .now_hms   (now_hms),
  .now_day   (now_day),
  .alm_hms   (alm_hms),
  .alm_day   (alm_day),
  .st_wr     (st_wr),
  .wdata     (bus_wdata),
  .status_q  (status_q),
  .enable_q  (enable_q),
  .irq       (irq)
);

// File: tb/daytime_rtc_tb.sv
module daytime_rtc_tb;

  localparam int unsigned TDIV_A = 16;
  localparam int unsigned TDIV_B = 20;
  localparam int unsigned TDIV_C = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  daytime_rtc #(
    .DIV_A(TDIV_A),
    .DIV_B(TDIV_B),
    .DIV_C(TDIV_C)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  typedef struct packed {
    logic [5:0]  a;
    logic [15:0] w;
    logic [15:0] e;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [0:NV-1] = '{
    '{6'h00, 16'h1734, 16'h1734},
    '{6'h00, 16'hFFFF, 16'h1F3F},
    '{6'h04, 16'hFFFF, 16'h003F},
    '{6'h04, 16'h002A, 16'h002A},
    '{6'h20, 16'hABCD, 16'hABCD},
    '{6'h08, 16'hFFFF, 16'h1F3F},
    '{6'h0C, 16'h0015, 16'h0015},
    '{6'h24, 16'h0102, 16'h0102},
    '{6'h18, 16'hFFFF, 16'h0094},
    '{6'h10, 16'hFFFF, 16'h00E0},
    '{6'h14, 16'hFFFF, 16'h0000},
    '{6'h10, 16'h0000, 16'h0000},
    '{6'h18, 16'h0000, 16'h0000}
  };

  function automatic string tag_for(logic [5:0] a);
    case (a)
      6'h10:   return "R2";
      6'h14:   return "R9";
      6'h18:   return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_tick = 1'b1;
    end
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  // A bus write that lands in the same cycle as a reference tick
  task automatic wr_with_tick(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    ref_tick  = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    ref_tick  = 1'b0;
    bus_we    = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 10; i++) begin
      rd(6'(i * 4), v);
      check("R1 reset read", v, 16'h0000);
    end
    check("R1 irq after reset", {15'b0, irq}, 16'h0000);

    // R6 / R2 / R9 / R10: register layout and masking via table
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].a, VECS[i].w);
      rd(VECS[i].a, v);
      check(tag_for(VECS[i].a), v, VECS[i].e);
    end

    // R2: stopped clock ignores ticks
    wr(6'h04, 16'h0000);
    wr(6'h10, 16'h0000);
    ticks(40);
    rd(6'h04, v);  check("R2 seconds held while stopped", v, 16'h0000);
    rd(6'h14, v);  check("R2 no status while stopped", v, 16'h0000);

    // R3 / R4: select 00
    wr(6'h10, 16'h0080);
    ticks(TDIV_A - 1);
    rd(6'h04, v);  check("R3 sel00 one tick short", v, 16'h0000);
    rd(6'h14, v);  check("R4 half-second only", v, 16'h0080);
    ticks(1);
    rd(6'h04, v);  check("R3 sel00 second", v, 16'h0001);
    rd(6'h14, v);  check("R4 both beats", v, 16'h0090);
    wr(6'h14, 16'h0010);
    rd(6'h14, v);  check("R9 clear one bit only", v, 16'h0080);
    wr(6'h14, 16'h0080);
    rd(6'h14, v);  check("R9 clear remaining", v, 16'h0000);

    // R3: select 01
    wr(6'h10, 16'h00A0);
    ticks(TDIV_B - 1);
    rd(6'h04, v);  check("R3 sel01 one tick short", v, 16'h0001);
    ticks(1);
    rd(6'h04, v);  check("R3 sel01 second", v, 16'h0002);

    // R3: select 10
    wr(6'h10, 16'h00C0);
    ticks(TDIV_C - 1);
    rd(6'h04, v);  check("R3 sel10 one tick short", v, 16'h0002);
    ticks(1);
    rd(6'h04, v);  check("R3 sel10 second", v, 16'h0003);

    // R3: select 11 acts as 00
    wr(6'h10, 16'h00E0);
    ticks(TDIV_A);
    rd(6'h04, v);  check("R3 sel11 second", v, 16'h0004);

    // R5: carry chain and day wrap
    wr(6'h10, 16'h0080);
    wr(6'h20, 16'hFFFF);
    wr(6'h00, 16'h173B);
    wr(6'h04, 16'h003B);
    ticks(TDIV_A);
    rd(6'h04, v);  check("R5 full wrap seconds", v, 16'h0000);
    rd(6'h00, v);  check("R5 full wrap hour/min", v, 16'h0000);
    rd(6'h20, v);  check("R5 day wraps to zero", v, 16'h0000);
    wr(6'h00, 16'h0A05);
    wr(6'h04, 16'h003B);
    ticks(TDIV_A);
    rd(6'h00, v);  check("R5 minute carry", v, 16'h0A06);
    wr(6'h00, 16'h053B);
    wr(6'h04, 16'h003B);
    ticks(TDIV_A);
    rd(6'h00, v);  check("R5 hour carry", v, 16'h0600);
    rd(6'h20, v);  check("R5 day held on hour carry", v, 16'h0000);

    // R8 / R10: alarm
    wr(6'h24, 16'h0005);
    wr(6'h08, 16'h0102);
    wr(6'h0C, 16'h0003);
    wr(6'h20, 16'h0005);
    wr(6'h00, 16'h0102);
    wr(6'h04, 16'h0002);
    wr(6'h14, 16'hFFFF);
    wr(6'h18, 16'h0004);
    ticks(TDIV_A);
    rd(6'h14, v);  check("R8 alarm sets on match step", v, 16'h0094);
    check("R10 irq on enabled alarm", {15'b0, irq}, 16'h0001);
    wr(6'h14, 16'h0004);
    rd(6'h14, v);  check("R9 alarm cleared", v, 16'h0090);
    check("R10 irq low with only masked bits", {15'b0, irq}, 16'h0000);
    ticks(TDIV_A);
    rd(6'h14, v);  check("R8 no alarm past match", v & 16'h0004, 16'h0000);
    wr(6'h24, 16'h0006);
    wr(6'h04, 16'h0002);
    ticks(TDIV_A);
    rd(6'h14, v);  check("R8 no alarm when day differs", v & 16'h0004, 16'h0000);
    wr(6'h18, 16'h0010);
    check("R10 status set while disabled raises irq", {15'b0, irq}, 16'h0001);
    wr(6'h18, 16'h0000);

    // R7: write in the step cycle wins, no advance
    wr(6'h04, 16'h000A);
    ticks(TDIV_A - 1);
    wr_with_tick(6'h04, 16'h0014);
    rd(6'h04, v);  check("R7 write wins over step", v, 16'h0014);
    rd(6'h00, v);  check("R7 other fields unchanged", v, 16'h0102);
    ticks(TDIV_A);
    rd(6'h04, v);  check("R7 counting resumes", v, 16'h0015);

    // R9: event beats a clear in the same cycle
    wr(6'h14, 16'hFFFF);
    ticks(TDIV_A - 1);
    wr_with_tick(6'h14, 16'h0010);
    rd(6'h14, v);  check("R9 set wins over clear", v & 16'h0010, 16'h0010);
    wr(6'h14, 16'h0010);
    rd(6'h14, v);  check("R9 later clear works", v & 16'h0010, 16'h0000);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(6'h04, v);  check("R1 seconds after reset", v, 16'h0000);
    rd(6'h10, v);  check("R1 control after reset", v, 16'h0000);
    rd(6'h24, v);  check("R1 day alarm after reset", v, 16'h0000);
    check("R1 irq after second reset", {15'b0, irq}, 16'h0000);

    finish_run();
  end

endmodule